// File: doc/BRIEF.md
# SMBus Slave Message Decoder

This block is a two-wire management-link slave that lets an external microcontroller exchange short messages with the host chip. It watches the clock and data lines through synchronisers. It recognises START and STOP conditions. It decodes three message classes: a Byte Write of one command byte and one data byte, a Byte Read that returns one byte of chip state chosen by a command byte, and a Host Notify carrying a device address and a 16-bit payload. No packet error code byte is sent or expected, so each message is complete without one.

The data line is open-drain. The block only pulls it low through `sda_oe`, and the board or bench forms the wired-AND. A simple host register port exposes the slave address, the captured bytes, two sticky status flags and their enables. The flags are cleared by writing a 1 to them. A notify message raises `notify_irq`. A completed write or read raises `msg_smi`. If both lines sit high for a programmable number of cycles while a transfer is in progress, the slave drops back to idle.

Top module: `smb_slave_decoder`

## Requirements
- R1: After reset, host register 0 (own 7-bit address in bits [6:0]) reads 44h. Register 3 (status) and register 4 (enables) read 00h. `sda_oe`, `notify_irq` and `msg_smi` are low.
- R2: The first byte after a START carries the 7-bit address in bits [7:1] and R/W in bit 0, where 0 means write. The slave ACKs only its own address, so 88h and 89h at the default address, or the notify target byte 10h. For any other address it never drives SDA, and it changes SDA only while SCL is low.
- R3: For a Byte Write (own address with W, then a command byte, then a data byte), all three bytes are ACKed. Register 1 then holds the data byte, register 2 holds the command byte, and status bit 1 sets as soon as the data byte is taken, with no further byte needed.
- R4: For a Byte Read (own address with W, command byte k, repeated START, own address with R), the slave returns chip-state byte k MSB first. Byte k is `state_bytes[8k+7:8k]`. The slave returns 00h when k is NUM_STATE or more. Status bit 1 sets once the byte has been sent.
- R5: For a Host Notify (10h, device byte, low byte, high byte), all four bytes are ACKed. Registers 5, 6 and 7 then hold the device, low and high bytes, and status bit 0 sets.
- R6: Writing register 3 clears each status bit whose written bit is 1 and leaves the others unchanged. A new event sets its bit even in the cycle of a clear.
- R7: `notify_irq` is high exactly when status bit 0 and enable bit 0 (register 4) are both set. `msg_smi` does the same for bit 1.
- R8: When SCL and SDA both stay high for IDLE_TO_CYC cycles during a transfer, the slave returns to idle. Bytes clocked afterwards without a new START are not ACKed and change no register.
- R9: A byte beyond the end of a Byte Write or a Host Notify is NACKed and leaves every register unchanged.
- R10: A read address that does not follow a command byte written in the same transfer is NACKed.
- R11: After the host writes a new address to register 0, the slave ACKs that address and NACKs the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | Pull data line low when 1 |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| state_bytes | input | 8*NUM_STATE | Chip-state bytes returned by reads |
| notify_irq | output | 1 | Notify interrupt request |
| msg_smi | output | 1 | Write/read message event request |

## Verification
The embedded assertions watch, on every cycle, that SDA changes only while the synchronised SCL is low, that a timeout sends the engine to idle, that a read phase only ever begins after a pending command byte, that a notify or write event lands in the status and data registers on the next cycle, and that a one-written status bit clears. Only the bench scenarios show the end-to-end message decoding: ACK/NACK patterns seen on the wire, the byte returned for each command index including out-of-range ones, extra bytes being refused, and the address taking effect after reprogramming.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } xfer_st_e;

    typedef enum logic [1:0] {
        MD_NONE, MD_WR, MD_RD, MD_NTF
    } xfer_md_e;

    localparam logic [6:0] NOTIFY_TGT   = 7'h08;
    localparam logic [6:0] DEF_SLV_ADDR = 7'h44;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_TO_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic idle_to
);
    localparam int CNT_W = $clog2(IDLE_TO_CYC + 1);
    localparam logic [CNT_W-1:0] LIM    = CNT_W'(IDLE_TO_CYC);
    localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(IDLE_TO_CYC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
        logic [CNT_W-1:0]       cnt;
    } mon_t;

    mon_t mon_d, mon_q;
    logic both_high;

    assign scl_s     = mon_q.scl_sync[SYNC_STAGES-1];
    assign sda_s     = mon_q.sda_sync[SYNC_STAGES-1];
    assign both_high = scl_s & sda_s;
    assign scl_rise  = scl_s & ~mon_q.scl_prev;
    assign scl_fall  = ~scl_s & mon_q.scl_prev;
    assign start_det = scl_s & mon_q.scl_prev & ~sda_s & mon_q.sda_prev;
    assign stop_det  = scl_s & mon_q.scl_prev & sda_s & ~mon_q.sda_prev;
    assign idle_to   = both_high && (mon_q.cnt == LIM_M1);

    always_comb begin
        mon_d          = mon_q;
        mon_d.scl_sync = {mon_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        mon_d.sda_sync = {mon_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        mon_d.scl_prev = scl_s;
        mon_d.sda_prev = sda_s;
        if (!both_high) begin
            mon_d.cnt = '0;
        end else if (mon_q.cnt != LIM) begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.scl_sync <= '1;
            mon_q.sda_sync <= '1;
            mon_q.scl_prev <= 1'b1;
            mon_q.sda_prev <= 1'b1;
            mon_q.cnt      <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_pkg::*;
#(
    parameter int NUM_STATE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_s,
    input  logic                   sda_s,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_det,
    input  logic                   stop_det,
    input  logic                   idle_to,
    input  logic [6:0]             slv_addr,
    input  logic [8*NUM_STATE-1:0] state_bytes,
    output logic                   sda_oe,
    output logic                   ev_wr,
    output logic                   ev_rd,
    output logic                   ev_ntf,
    output logic [7:0]             cap1,
    output logic [7:0]             cap2,
    output logic [7:0]             cap3
);
    typedef struct packed {
        xfer_st_e   st;
        xfer_md_e   md;
        logic [3:0] bitcnt;
        logic [2:0] byte_idx;
        logic [7:0] shreg;
        logic       pend_cmd;
        logic [7:0] cap1;
        logic [7:0] cap2;
        logic [7:0] cap3;
        logic       ev_wr;
        logic       ev_rd;
        logic       ev_ntf;
        logic       oe;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [7:0] sel_byte;
    logic       ack;

    always_comb begin
        sel_byte = 8'h00;
        for (int k = 0; k < NUM_STATE; k++) begin
            if (f_q.cap1 == 8'(k)) sel_byte = state_bytes[k*8 +: 8];
        end
    end

    always_comb begin
        f_d        = f_q;
        f_d.ev_wr  = 1'b0;
        f_d.ev_rd  = 1'b0;
        f_d.ev_ntf = 1'b0;
        ack        = 1'b0;
        case (f_q.st)
            ST_RX: begin
                if (scl_rise) begin
                    f_d.shreg  = {f_q.shreg[6:0], sda_s};
                    f_d.bitcnt = f_q.bitcnt + 4'd1;
                end
                if (scl_fall && f_q.bitcnt == 4'd8) begin
                    case (f_q.byte_idx)
                        3'd0: begin
                            if (f_q.shreg[7:1] == slv_addr) begin
                                if (!f_q.shreg[0]) begin
                                    f_d.md = MD_WR; ack = 1'b1;
                                end else if (f_q.pend_cmd) begin
                                    f_d.md = MD_RD; ack = 1'b1;
                                end
                            end else if (f_q.shreg == {NOTIFY_TGT, 1'b0}) begin
                                f_d.md = MD_NTF; ack = 1'b1;
                            end
                        end
                        3'd1: begin
                            if (f_q.md == MD_WR || f_q.md == MD_NTF) begin
                                f_d.cap1     = f_q.shreg;
                                f_d.pend_cmd = (f_q.md == MD_WR);
                                ack          = 1'b1;
                            end
                        end
                        3'd2: begin
                            if (f_q.md == MD_WR || f_q.md == MD_NTF) begin
                                f_d.cap2     = f_q.shreg;
                                f_d.ev_wr    = (f_q.md == MD_WR);
                                f_d.pend_cmd = 1'b0;
                                ack          = 1'b1;
                            end
                        end
                        3'd3: begin
                            if (f_q.md == MD_NTF) begin
                                f_d.cap3   = f_q.shreg;
                                f_d.ev_ntf = 1'b1;
                                ack        = 1'b1;
                            end
                        end
                        default: ack = 1'b0;
                    endcase
                    f_d.bitcnt = 4'd0;
                    if (ack) begin
                        f_d.st       = ST_ACK;
                        f_d.oe       = 1'b1;
                        f_d.byte_idx = f_q.byte_idx + 3'd1;
                    end else begin
                        f_d.st = ST_WAIT;
                        f_d.oe = 1'b0;
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    f_d.bitcnt = 4'd0;
                    if (f_q.md == MD_RD) begin
                        f_d.st    = ST_TX;
                        f_d.shreg = sel_byte;
                        f_d.oe    = ~sel_byte[7];
                    end else begin
                        f_d.st = ST_RX;
                        f_d.oe = 1'b0;
                    end
                end
            end
            ST_TX: begin
                if (scl_rise) f_d.bitcnt = f_q.bitcnt + 4'd1;
                if (scl_fall) begin
                    if (f_q.bitcnt == 4'd8) begin
                        f_d.st    = ST_MACK;
                        f_d.oe    = 1'b0;
                        f_d.ev_rd = 1'b1;
                    end else begin
                        f_d.shreg = {f_q.shreg[6:0], 1'b0};
                        f_d.oe    = ~f_q.shreg[6];
                    end
                end
            end
            ST_MACK: begin
                if (scl_fall) begin
                    f_d.st       = ST_WAIT;
                    f_d.pend_cmd = 1'b0;
                end
            end
            default: f_d.oe = 1'b0;
        endcase
        if (start_det) begin
            f_d.st       = ST_RX;
            f_d.md       = MD_NONE;
            f_d.bitcnt   = 4'd0;
            f_d.byte_idx = 3'd0;
            f_d.oe       = 1'b0;
        end
        if (stop_det || idle_to) begin
            f_d.st       = ST_IDLE;
            f_d.md       = MD_NONE;
            f_d.oe       = 1'b0;
            f_d.pend_cmd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q          <= '0;
            f_q.st       <= ST_IDLE;
            f_q.md       <= MD_NONE;
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe = f_q.oe;
    assign ev_wr  = f_q.ev_wr;
    assign ev_rd  = f_q.ev_rd;
    assign ev_ntf = f_q.ev_ntf;
    assign cap1   = f_q.cap1;
    assign cap2   = f_q.cap2;
    assign cap3   = f_q.cap3;

    // R2: the slave moves SDA only while the synchronised SCL is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.oe != $past(f_q.oe)) |-> !scl_s);

    // R8: a bus-idle timeout returns the engine to idle
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_to |=> (f_q.st == ST_IDLE));

    // R10: a read phase starts only with a command byte pending
    a_r10_read_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.md == MD_RD) |-> $past(f_q.pend_cmd));
endmodule

// File: rtl/smb_slave_decoder.sv
module smb_slave_decoder
    import smb_pkg::*;
#(
    parameter int NUM_STATE   = 4,
    parameter int IDLE_TO_CYC = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic                   host_we,
    input  logic [2:0]             host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    input  logic [8*NUM_STATE-1:0] state_bytes,
    output logic                   notify_irq,
    output logic                   msg_smi
);
    typedef struct packed {
        logic [6:0] slv;
        logic [7:0] wr_data;
        logic [7:0] wr_cmd;
        logic [1:0] stat;
        logic [1:0] en;
        logic [7:0] ntf_dev;
        logic [7:0] ntf_lo;
        logic [7:0] ntf_hi;
    } regs_t;

    regs_t r_d, r_q;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, idle_to;
    logic ev_wr, ev_rd, ev_ntf;
    logic [7:0] cap1, cap2, cap3;
    logic [1:0] clr_mask;

    smb_line_mon #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_TO_CYC (IDLE_TO_CYC)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .idle_to   (idle_to)
    );

    smb_xfer_fsm #(
        .NUM_STATE (NUM_STATE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .idle_to     (idle_to),
        .slv_addr    (r_q.slv),
        .state_bytes (state_bytes),
        .sda_oe      (sda_oe),
        .ev_wr       (ev_wr),
        .ev_rd       (ev_rd),
        .ev_ntf      (ev_ntf),
        .cap1        (cap1),
        .cap2        (cap2),
        .cap3        (cap3)
    );

    always_comb begin
        r_d      = r_q;
        clr_mask = (host_we && host_addr == 3'd3) ? host_wdata[1:0] : 2'b00;
        if (host_we && host_addr == 3'd0) r_d.slv = host_wdata[6:0];
        if (host_we && host_addr == 3'd4) r_d.en  = host_wdata[1:0];
        if (ev_wr) begin
            r_d.wr_cmd  = cap1;
            r_d.wr_data = cap2;
        end
        if (ev_ntf) begin
            r_d.ntf_dev = cap1;
            r_d.ntf_lo  = cap2;
            r_d.ntf_hi  = cap3;
        end
        r_d.stat = (r_q.stat & ~clr_mask) | {ev_wr | ev_rd, ev_ntf};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.slv <= DEF_SLV_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (host_addr)
            3'd0:    host_rdata = {1'b0, r_q.slv};
            3'd1:    host_rdata = r_q.wr_data;
            3'd2:    host_rdata = r_q.wr_cmd;
            3'd3:    host_rdata = {6'b0, r_q.stat};
            3'd4:    host_rdata = {6'b0, r_q.en};
            3'd5:    host_rdata = r_q.ntf_dev;
            3'd6:    host_rdata = r_q.ntf_lo;
            default: host_rdata = r_q.ntf_hi;
        endcase
    end

    assign notify_irq = r_q.stat[0] & r_q.en[0];
    assign msg_smi    = r_q.stat[1] & r_q.en[1];

    // R5: a completed notify sets status bit 0
    a_r5_notify_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ntf |=> r_q.stat[0]);

    // R3: the write data byte lands in the data register
    a_r3_write_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr |=> (r_q.wr_data == $past(cap2)));

    // R6: writing one clears status bit 0 when no notify arrives
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd3 && host_wdata[0] && !ev_ntf) |=> !r_q.stat[0]);
endmodule

// File: tb/smb_slave_decoder_tb.sv
module smb_slave_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_STATE  = 4;
    localparam int TO_CYC     = 40;

    typedef struct packed {
        logic [1:0] kind;     // 0 write, 1 read, 2 notify
        logic [7:0] addr;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [7:0] p2;
        logic       exp_ack;
        logic [7:0] exp_val;
        logic [1:0] exp_stat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h88, 8'h05, 8'hA5, 8'h00, 1'b1, 8'hA5, 2'd2},
        '{2'd0, 8'h88, 8'h06, 8'h3C, 8'h00, 1'b1, 8'h3C, 2'd2},
        '{2'd0, 8'h8A, 8'h07, 8'hFF, 8'h00, 1'b0, 8'h3C, 2'd0},
        '{2'd1, 8'h88, 8'h02, 8'h00, 8'h00, 1'b1, 8'hAD, 2'd2},
        '{2'd1, 8'h88, 8'h00, 8'h00, 8'h00, 1'b1, 8'hEF, 2'd2},
        '{2'd1, 8'h88, 8'h09, 8'h00, 8'h00, 1'b1, 8'h00, 2'd2},
        '{2'd2, 8'h10, 8'h2A, 8'h11, 8'h22, 1'b1, 8'h11, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [8*NUM_STATE-1:0] state_bytes = 32'hDEADBEEF;
    logic notify_irq, msg_smi;
    int nchk = 0;
    int nfail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_slave_decoder #(
        .NUM_STATE   (NUM_STATE),
        .IDLE_TO_CYC (TO_CYC),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .state_bytes (state_bytes),
        .notify_irq  (notify_irq),
        .msg_smi     (msg_smi)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk) host_addr = a;
        @(negedge clk) d = host_rdata;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk) begin host_we = 1'b1; host_addr = a; host_wdata = d; end
        @(negedge clk) host_we = 1'b0;
    endtask

    task automatic bus_start();
        scl_m = 1'b0; sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b0; tick(8);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; tick(4);
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(8);
        end
        scl_m = 1'b0; tick(4);
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        ack = ~sda_line; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic read_byte(output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b0; tick(8);
            scl_m = 1'b1; tick(4);
            b = {b[6:0], sda_line}; tick(4);
        end
        scl_m = 1'b0; tick(4);
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(8);
        scl_m = 1'b0; tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic a0, a1, a2, a3;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        reg_rd(3'd0, d); chk("R1 addr", d, 8'h44);
        reg_rd(3'd3, d); chk("R1 stat", d, 8'h00);
        reg_rd(3'd4, d); chk("R1 en", d, 8'h00);
        chk("R1 pins", {5'b0, sda_oe, notify_irq, msg_smi}, 8'h00);

        // table: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            bus_start();
            send_byte(t.addr, a0);
            if (t.kind == 2'd1) begin
                send_byte(t.p0, a1);
                bus_start();
                send_byte(t.addr | 8'h01, a2);
                chk("R2 read addr ack", {7'b0, a2}, {7'b0, t.exp_ack});
                read_byte(d);
                chk("R4 read byte", d, t.exp_val);
            end else begin
                send_byte(t.p0, a1);
                send_byte(t.p1, a2);
                if (t.kind == 2'd2) send_byte(t.p2, a3);
            end
            bus_stop();
            chk("R2 addr ack", {7'b0, a0}, {7'b0, t.exp_ack});
            if (t.kind == 2'd0) begin
                reg_rd(3'd1, d); chk("R3 data reg", d, t.exp_val);
            end else if (t.kind == 2'd2) begin
                reg_rd(3'd6, d); chk("R5 notify low", d, t.exp_val);
                reg_rd(3'd5, d); chk("R5 notify dev", d, t.p0);
                reg_rd(3'd7, d); chk("R5 notify high", d, t.p2);
            end
            reg_rd(3'd3, d); chk("R3/R4/R5 status", d, {6'b0, t.exp_stat});
            reg_wr(3'd3, 8'h03);
        end
        reg_rd(3'd2, d); chk("R3 cmd reg", d, 8'h06);

        // R7 interrupts and R6 clear
        reg_wr(3'd4, 8'h03);
        bus_start(); send_byte(8'h10, a0); send_byte(8'h01, a1);
        send_byte(8'h02, a2); send_byte(8'h03, a3); bus_stop();
        tick(2);
        chk("R7 notify only", {6'b0, notify_irq, msg_smi}, 8'h02);
        bus_start(); send_byte(8'h88, a0); send_byte(8'h01, a1);
        send_byte(8'h55, a2); bus_stop();
        tick(2);
        chk("R7 both", {6'b0, notify_irq, msg_smi}, 8'h03);
        reg_wr(3'd3, 8'h01);
        tick(1);
        chk("R6 clear bit0", {6'b0, notify_irq, msg_smi}, 8'h01);
        reg_rd(3'd3, d); chk("R6 status", d, 8'h02);
        reg_wr(3'd4, 8'h00);
        tick(1);
        chk("R7 disabled", {6'b0, notify_irq, msg_smi}, 8'h00);
        reg_wr(3'd3, 8'h02);
        reg_rd(3'd3, d); chk("R6 cleared", d, 8'h00);

        // R8 idle timeout mid-transfer
        bus_start(); send_byte(8'h88, a0);
        scl_m = 1'b1; tick(2 * TO_CYC);
        scl_m = 1'b0; tick(4);
        send_byte(8'h77, a1);
        bus_stop();
        chk("R8 no ack after timeout", {7'b0, a1}, 8'h00);
        reg_rd(3'd2, d); chk("R8 cmd unchanged", d, 8'h01);

        // R9 extra byte refused
        bus_start(); send_byte(8'h88, a0); send_byte(8'h0A, a1);
        send_byte(8'h5A, a2); send_byte(8'h99, a3); bus_stop();
        chk("R9 extra nack", {7'b0, a3}, 8'h00);
        reg_rd(3'd1, d); chk("R9 data kept", d, 8'h5A);
        reg_wr(3'd3, 8'h03);

        // R10 read with no command
        bus_start(); send_byte(8'h89, a0); bus_stop();
        chk("R10 nack", {7'b0, a0}, 8'h00);
        reg_rd(3'd3, d); chk("R10 status", d, 8'h00);

        // R11 new address
        reg_wr(3'd0, 8'h12);
        bus_start(); send_byte(8'h24, a0); send_byte(8'h33, a1);
        send_byte(8'h44, a2); bus_stop();
        chk("R11 new addr ack", {7'b0, a0}, 8'h01);
        reg_rd(3'd1, d); chk("R11 data", d, 8'h44);
        bus_start(); send_byte(8'h88, a0); bus_stop();
        chk("R11 old addr nack", {7'b0, a0}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule